// File: doc/BRIEF.md
# Time-Shared Second-Order Recursive Filter

This block computes a second-order recursive (biquad) filter on a 16-bit signed sample stream. It uses a single two-input adder and a single multiplier. Each input sample takes four clock slots, numbered 0 to 3 by a wrapping schedule counter. In every slot the adder and the multiplier each carry out one of the eight graph operations. Each intermediate result is kept in a shared tap line for exactly as many slots as the consuming operation needs. The tap length for a result is the number of algorithmic delays on its edge times four, minus the producer's pipeline depth, plus the consumer's slot, minus the producer's slot.

The adder operations run in this order: the feed-forward partial sum in slot 0, the output sum in slot 1, the feedback sum in slot 2 and the state update in slot 3. The multiplier operations run in this order: first feedback tap in slot 0, second feed-forward tap in slot 1, first feed-forward tap in slot 2 and second feedback tap in slot 3. The adder has a one-stage pipeline and the multiplier a two-stage pipeline. The four coefficients are Q1.14 parameters.

Samples enter on a valid/ready port. `in_ready` is high only in slot 3, and a sample is taken on the edge where `in_valid` and `in_ready` are both high. If `in_valid` is low in that slot, the whole datapath and the counter freeze. Results leave through a one-entry output register with valid/ready. `out_valid` stays high and `out_data` stays constant until `out_ready` is seen. If the register is still full when the next result is due in slot 2, the datapath freezes until the consumer accepts.

Top module: `folded_biquad`

## Requirements
- R1: During and directly after reset, `out_valid` and `in_ready` are low and all filter history is zero.
- R2: `in_ready` is high only in schedule slot 3. After an accepted sample it drops for three advancing cycles. While `in_valid` stays low it remains high.
- R3: The state sequence obeys w(n) = x(n) + B1·w(n−1) + B2·w(n−2), where x(n) is the n-th accepted sample and w is zero before the first sample.
- R4: The n-th output (n counted from 0) is y(n) = w(n−1) + A1·w(n−2) + A2·w(n−3). The first output, y(0), therefore comes from the zero state before any input is accepted.
- R5: Each product is the full signed product shifted right arithmetically by 14, keeping the lowest 16 bits. Every sum wraps modulo 2^16 as 16-bit two's complement.
- R6: A stall in the input slot changes no result. The output stream is identical to an unstalled run, and no new output appears while the input slot waits.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R8: Exactly one output is produced per accepted sample, plus the initial y(0). Outputs appear in order, and each new result raises `out_valid` in the cycle in which `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block takes a sample this cycle (slot 3) |
| in_data | input | DW | Signed input sample x |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer accepts the held result |
| out_data | output | DW | Signed output sample y |

## Verification
A wrong tap index or a wrong slot assignment mixes samples from the wrong iteration. The error shows up in `out_data` within one to three outputs after a nonzero sample, because each output draws on the three latest states. A fault in the feedback path corrupts every later output. A fault in the stall or counter logic shows up at once as `in_ready` outside its slot, or as a dropped, duplicated or changed held output. Driving inputs with irregular gaps and outputs with back-pressure exposes any piece of state that keeps advancing while the schedule is frozen.

// File: rtl/fbq_pkg.sv
package fbq_pkg;

  localparam int FOLD_N = 4;
  localparam int P_ADD  = 1;
  localparam int P_MUL  = 2;

  typedef enum logic [1:0] {
    SLOT0 = 2'd0,
    SLOT1 = 2'd1,
    SLOT2 = 2'd2,
    SLOT3 = 2'd3
  } slot_e;

  // slot of each operation on its shared unit
  localparam int ORD_N4 = 0;  // feed-forward partial sum
  localparam int ORD_N2 = 1;  // output sum
  localparam int ORD_N3 = 2;  // feedback sum
  localparam int ORD_N1 = 3;  // state update
  localparam int ORD_N5 = 0;  // B1 * w
  localparam int ORD_N8 = 1;  // A2 * w
  localparam int ORD_N6 = 2;  // A1 * w
  localparam int ORD_N7 = 3;  // B2 * w

  function automatic int fold_delay(input int w, input int p, input int u, input int v);
    return FOLD_N * w - p + v - u;
  endfunction

  localparam int DF_1_2 = fold_delay(1, P_ADD, ORD_N1, ORD_N2);
  localparam int DF_1_5 = fold_delay(1, P_ADD, ORD_N1, ORD_N5);
  localparam int DF_1_6 = fold_delay(1, P_ADD, ORD_N1, ORD_N6);
  localparam int DF_1_7 = fold_delay(1, P_ADD, ORD_N1, ORD_N7);
  localparam int DF_1_8 = fold_delay(2, P_ADD, ORD_N1, ORD_N8);
  localparam int DF_3_1 = fold_delay(0, P_ADD, ORD_N3, ORD_N1);
  localparam int DF_4_2 = fold_delay(0, P_ADD, ORD_N4, ORD_N2);
  localparam int DF_5_3 = fold_delay(0, P_MUL, ORD_N5, ORD_N3);
  localparam int DF_6_4 = fold_delay(1, P_MUL, ORD_N6, ORD_N4);
  localparam int DF_7_3 = fold_delay(1, P_MUL, ORD_N7, ORD_N3);
  localparam int DF_8_4 = fold_delay(1, P_MUL, ORD_N8, ORD_N4);

  localparam int ADD_TAPS = DF_1_8;
  localparam int MUL_TAPS = DF_7_3;

endpackage

// File: rtl/fbq_sched.sv
module fbq_sched
  import fbq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  logic  out_block,
  output slot_e slot,
  output logic  step,
  output logic  in_ready
);

  always_comb begin
    step = 1'b1;
    if (slot == SLOT3 && !in_valid) step = 1'b0;
    if (slot == SLOT2 && out_block) step = 1'b0;
  end

  assign in_ready = (slot == SLOT3);

  always_ff @(posedge clk) begin
    if (!rst_n)     slot <= SLOT0;
    else if (step)  slot <= slot_e'(slot + 2'd1);
  end

  // R2: slot waits while the producer is idle
  a_r2_wait_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  // R2: accepted sample leaves the input slot
  a_r2_leave_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> !in_ready);

endmodule

// File: rtl/fbq_adder.sv
module fbq_adder #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (en)  q <= a + b;
  end

endmodule

// File: rtl/fbq_mult.sv
module fbq_mult #(
  parameter int DW   = 16,
  parameter int FRAC = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] q
);

  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      q      <= '0;
    end else if (en) begin
      prod_q <= $signed(a) * $signed(b);
      q      <= DW'(prod_q >>> FRAC);
    end
  end

endmodule

// File: rtl/fbq_tapline.sv
module fbq_tapline #(
  parameter int DW    = 16,
  parameter int DEPTH = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [DW-1:0]           d,
  output logic [DEPTH:0][DW-1:0]  taps
);

  assign taps[0] = d;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)   taps[k] <= '0;
      else if (en)  taps[k] <= taps[k-1];
    end
  end

endmodule

// File: rtl/folded_biquad.sv
module folded_biquad
  import fbq_pkg::*;
#(
  parameter int              DW      = 16,
  parameter int              FRAC    = 14,
  parameter logic [DW-1:0]   COEF_B1 = 16'sd8192,
  parameter logic [DW-1:0]   COEF_B2 = -16'sd4096,
  parameter logic [DW-1:0]   COEF_A1 = 16'sd12288,
  parameter logic [DW-1:0]   COEF_A2 = -16'sd8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  localparam int AIW = $clog2(ADD_TAPS + 1);

  slot_e slot;
  logic  step;
  logic  out_block;
  logic  y_full;
  logic  capture;

  logic [DW-1:0] add_a, add_b, add_q;
  logic [DW-1:0] mul_c, mul_v, mul_q;
  logic [AIW-1:0] mul_idx;
  logic [ADD_TAPS:0][DW-1:0] a_tap;
  logic [MUL_TAPS:0][DW-1:0] m_tap;

  assign out_block = y_full && !out_ready;
  assign capture   = step && (slot == SLOT2);

  fbq_sched u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_block (out_block),
    .slot      (slot),
    .step      (step),
    .in_ready  (in_ready)
  );

  always_comb begin
    add_a   = '0;
    add_b   = '0;
    mul_c   = '0;
    mul_idx = '0;
    unique case (slot)
      SLOT0: begin
        add_a   = m_tap[DF_6_4];
        add_b   = m_tap[DF_8_4];
        mul_c   = COEF_B1;
        mul_idx = AIW'(DF_1_5);
      end
      SLOT1: begin
        add_a   = a_tap[DF_1_2];
        add_b   = a_tap[DF_4_2];
        mul_c   = COEF_A2;
        mul_idx = AIW'(DF_1_8);
      end
      SLOT2: begin
        add_a   = m_tap[DF_5_3];
        add_b   = m_tap[DF_7_3];
        mul_c   = COEF_A1;
        mul_idx = AIW'(DF_1_6);
      end
      SLOT3: begin
        add_a   = in_data;
        add_b   = a_tap[DF_3_1];
        mul_c   = COEF_B2;
        mul_idx = AIW'(DF_1_7);
      end
      default: ;
    endcase
  end

  assign mul_v = a_tap[mul_idx];

  fbq_adder #(.DW(DW)) u_add (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step),
    .a     (add_a),
    .b     (add_b),
    .q     (add_q)
  );

  fbq_mult #(.DW(DW), .FRAC(FRAC)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step),
    .a     (mul_c),
    .b     (mul_v),
    .q     (mul_q)
  );

  fbq_tapline #(.DW(DW), .DEPTH(ADD_TAPS)) u_add_taps (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step),
    .d     (add_q),
    .taps  (a_tap)
  );

  fbq_tapline #(.DW(DW), .DEPTH(MUL_TAPS)) u_mul_taps (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step),
    .d     (mul_q),
    .taps  (m_tap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_full   <= 1'b0;
      out_data <= '0;
    end else begin
      if (capture) begin
        y_full   <= 1'b1;
        out_data <= add_q;
      end else if (out_ready) begin
        y_full   <= 1'b0;
      end
    end
  end

  assign out_valid = y_full;

  // R7: held result keeps valid and data
  a_r7_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: a fresh result appears as the schedule reaches the input slot
  a_r8_result_before_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> in_ready);

  // R6: waiting for input produces no new result
  a_r6_no_output_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid && !out_valid) |=> !out_valid);

endmodule

// File: tb/folded_biquad_bench.sv
module folded_biquad_bench;

  localparam logic signed [15:0] B1 = 16'sd8192;
  localparam logic signed [15:0] B2 = -16'sd4096;
  localparam logic signed [15:0] A1 = 16'sd12288;
  localparam logic signed [15:0] A2 = -16'sd8192;

  localparam int NV = 20;
  localparam logic signed [15:0] TX [NV] = '{
    16'sd16384, 16'sd0, 16'sd0, 16'sd0, -16'sd16384, 16'sd32767, 16'sd32767,
    -16'sd32768, 16'sd1000, -16'sd1000, 16'sd12345, 16'sd0, 16'sd8000,
    -16'sd8000, 16'sd20000, 16'sd20000, -16'sd20000, 16'sd5, -16'sd5, 16'sd30000};
  localparam int TG [NV] = '{0,0,2,0,1,0,3,0,0,1,0,2,0,0,1,0,0,3,0,0};
  localparam int BP_FROM = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [15:0] out_data;

  int checks = 0;
  int fails = 0;
  int out_idx = 0;
  int nx = 0;
  bit bp = 1'b0;
  int cyc = 0;

  logic signed [15:0] xin [32];
  logic signed [15:0] wst [32];
  logic signed [15:0] exp_y [33];

  always #2.5 clk = ~clk;

  folded_biquad #(
    .COEF_B1(B1), .COEF_B2(B2), .COEF_A1(A1), .COEF_A2(A2)
  ) u_folded_biquad (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // R5 arithmetic model
  function automatic logic signed [15:0] qmul(input logic signed [15:0] c,
                                              input logic signed [15:0] v);
    int p;
    p = c * v;
    p = p >>> 14;
    return p[15:0];
  endfunction

  function automatic logic signed [15:0] wg(input int i);
    return (i < 0) ? 16'sd0 : wst[i];
  endfunction

  task automatic build_expect();
    logic signed [15:0] t, f;
    for (int n = 0; n < nx; n++) begin
      t = qmul(B1, wg(n-1)) + qmul(B2, wg(n-2));   // R3
      wst[n] = xin[n] + t;
    end
    for (int k = 0; k <= nx; k++) begin
      f = qmul(A1, wg(k-2)) + qmul(A2, wg(k-3));   // R4
      exp_y[k] = wg(k-1) + f;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = bp ? ((cyc % 5) == 0) : 1'b1;
  end

  // consumer: compares each accepted output, and R7 holding
  bit held = 1'b0;
  logic [15:0] held_d;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held)
        check(out_valid && out_data == held_d, "R7", int'($signed(out_data)), int'($signed(held_d)));
      if (out_valid && out_ready) begin
        if (out_idx > nx)
          check(1'b0, "R8 extra output", out_idx, nx);
        else
          check($signed(out_data) == exp_y[out_idx], (out_idx < 4) ? "R4" : "R3/R5",
                int'($signed(out_data)), int'(exp_y[out_idx]));
        out_idx++;
      end
      held = out_valid && !out_ready;
      held_d = out_data;
    end else begin
      held = 1'b0;
    end
  end

  task automatic send(input logic signed [15:0] x, input int gap);
    repeat (gap) @(posedge clk);
    #1;
    in_valid = 1'b1;
    in_data  = x;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", out_idx, nx + 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    nx = NV;
    for (int i = 0; i < NV; i++) xin[i] = TX[i];
    build_expect();

    repeat (3) @(negedge clk);
    check(!out_valid, "R1 out_valid", int'(out_valid), 0);
    check(!in_ready, "R1 in_ready", int'(in_ready), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!in_ready && !out_valid, "R1 after reset", int'(in_ready), 0);

    // table walk: inputs with gaps (R6), back-pressure later (R7)
    for (int i = 0; i < NV; i++) begin
      if (i == BP_FROM) bp = 1'b1;
      send(TX[i], TG[i]);
    end
    bp = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(out_idx == NV + 1, "R8 count", out_idx, NV + 1);
    check(!out_valid, "R6 idle output", int'(out_valid), 0);
    check(in_ready, "R2 waits in slot", int'(in_ready), 1);

    // reset mid-stream, then fresh impulse sequence from zero state
    @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!out_valid && !in_ready, "R1 mid reset", int'(out_valid), 0);
    nx = 3;
    xin[0] = 16'sd16384; xin[1] = 16'sd0; xin[2] = -16'sd32768;
    build_expect();
    out_idx = 0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 3; i++) send(xin[i], 2);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(out_idx == 4, "R8 count after reset", out_idx, 4);
    check(exp_y[0] == 0 && exp_y[1] == 16384, "R4 model", int'(exp_y[1]), 16384);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule